// File: doc/BRIEF.md
# Mixed-Polarity External Interrupt Flag Bank

This block captures edge events on four asynchronous external interrupt pins into four sticky request flags. The flags occupy the upper nibble of one 8-bit control register, which is decoded at a fixed address (91h by default). Each pin is re-timed by a two-stage synchroniser. A small per-pin level tracker then turns a level change into a one-cycle edge pulse.

The sources do not share a polarity. Sources 0 and 2 (interrupt lines 2 and 4) react to a rising edge. Sources 1 and 3 (interrupt lines 3 and 5) react to a falling edge. The edges in the opposite direction are ignored. Software reads the register to see which sources are pending, and it acknowledges a source by writing a 0 to that flag's bit. The block drives one request line per flag and a registered combined request.

Each level tracker is a two-state machine with the states `LVL_LOW` and `LVL_HIGH`. It has three transitions:
- **rise**: from `LVL_LOW` to `LVL_HIGH`. This raises the edge pulse on rising sources.
- **fall**: from `LVL_HIGH` to `LVL_LOW`. This raises the edge pulse on falling sources.
- **reset load**: while reset is held, the tracker is loaded with the synchronised pin level.

Top module: `xint_flag_bank`

## Requirements
- R1: While reset is asserted, every flag and `irq_any` read as 0 on the following clock edge.
- R2: Releasing reset produces no flag, whatever level the pins held during reset.
- R3: A read at address 91h returns {src3, src2, src1, src0} in bits 7..4 and zeros in bits 3..0. A read at any other address returns 0.
- R4: Sources 0 and 2 set their flag on a rising pin edge (0 to 1). A falling edge on them leaves the flag unchanged.
- R5: Sources 1 and 3 set their flag on a falling pin edge (1 to 0). A rising edge on them leaves the flag unchanged.
- R6: A flag becomes visible on the third rising clock edge after its pin changes, and not on the second.
- R7: A write to address 91h clears each flag whose data bit (bit 4 + source index) is 0. It keeps flags whose bit is 1 and ignores bits 3..0. Writes to other addresses change no flag.
- R8: When a flag's setting edge and a clearing write take effect on the same clock edge, the flag ends up set.
- R9: `irq_flag[i]` mirrors flag i. `irq_any` equals the OR of the flags one clock later.
- R10: A set flag stays set, through further edges on any pin, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xint_pin | input | 4 | Asynchronous interrupt pins; bit i is source i (interrupt lines 2..5) |
| reg_addr | input | 8 | Register address for read and write |
| reg_wr_en | input | 1 | Write strobe, one cycle |
| reg_wr_data | input | 8 | Write data; a 0 in bit 4+i clears flag i |
| reg_rd_data | output | 8 | Combinational read data |
| irq_flag | output | 4 | Per-source pending flags |
| irq_any | output | 1 | Registered OR of all flags |

## Verification
The hardest case to reach from the ports is the collision: a clearing write that lands on the exact clock edge at which a pin edge emerges from the synchroniser. The stimulus reaches it by driving the pin on a falling clock edge, counting two rising edges for the synchroniser stages, and then raising the write strobe so that it takes effect on the third edge. Polarity is swept over every source in both directions, and every acknowledge mask is swept with all flags pending.

// File: rtl/xint_pkg.sv
package xint_pkg;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    // Even sources react to rising edges, odd sources to falling edges.
    function automatic bit src_is_rising(input int idx);
        return (idx % 2) == 0;
    endfunction

endpackage

// File: rtl/xint_sync2.sv
module xint_sync2 #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // No reset: the chain keeps sampling so trackers can load the true level.
    always_ff @(posedge clk) begin
        stage1_q <= d_i;
        stage2_q <= stage1_q;
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/xint_edge_fsm.sv
module xint_edge_fsm
    import xint_pkg::*;
#(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic edge_o
);
    lvl_state_e state_q;
    lvl_state_e state_d;

    // State register: reset load follows the synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= lvl_i ? LVL_HIGH : LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
        endcase
    end

    // Outputs: edge pulse on the transition matching the polarity.
    always_comb begin
        edge_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  edge_o = lvl_i && RISING;
            LVL_HIGH: edge_o = !lvl_i && !RISING;
        endcase
    end
endmodule

// File: rtl/xint_flag_cell.sv
module xint_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/xint_flag_bank.sv
module xint_flag_bank
    import xint_pkg::*;
#(
    parameter int                N_SRC    = 4,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h91
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  xint_pin,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wr_data,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic [N_SRC-1:0]  irq_flag,
    output logic              irq_any
);
    localparam int FLAG_LSB = DATA_W - N_SRC;

    logic [N_SRC-1:0] pin_sync;
    logic [N_SRC-1:0] edge_hit;
    logic [N_SRC-1:0] clr_vec;
    logic [N_SRC-1:0] flag_vec;
    logic             reg_hit;
    logic             any_q;

    assign reg_hit = (reg_addr == REG_ADDR);

    xint_sync2 #(.WIDTH(N_SRC)) u_sync (
        .clk (clk),
        .d_i (xint_pin),
        .q_o (pin_sync)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign clr_vec[i] = reg_wr_en && reg_hit && !reg_wr_data[FLAG_LSB + i];

        xint_edge_fsm #(.RISING(src_is_rising(i))) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pin_sync[i]),
            .edge_o (edge_hit[i])
        );

        xint_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (edge_hit[i]),
            .clr_i  (clr_vec[i]),
            .flag_o (flag_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            any_q <= 1'b0;
        end else begin
            any_q <= |flag_vec;
        end
    end

    always_comb begin
        reg_rd_data = '0;
        if (reg_hit) begin
            reg_rd_data[DATA_W-1 -: N_SRC] = flag_vec;
        end
    end

    assign irq_flag = flag_vec;
    assign irq_any  = any_q;
endmodule

// File: rtl/xint_flag_bank_chk.sv
module xint_flag_bank_chk
    import xint_pkg::*;
#(
    parameter int                N_SRC    = 4,
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h91
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  xint_pin,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic [DATA_W-1:0] reg_rd_data,
    input logic [N_SRC-1:0]  irq_flag,
    input logic              irq_any
);
    localparam int FLAG_LSB = DATA_W - N_SRC;

    logic [N_SRC-1:0] ack_mask;
    always_comb begin
        ack_mask = '0;
        if (reg_wr_en && reg_addr == REG_ADDR) begin
            ack_mask = ~reg_wr_data[DATA_W-1 -: N_SRC];
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_flag == '0 && !irq_any));

    assert_read_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == REG_ADDR) |-> (reg_rd_data == {irq_flag, {FLAG_LSB{1'b0}}}));

    assert_read_other_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != REG_ADDR) |-> (reg_rd_data == '0));

    assert_any_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_any == $past(|irq_flag)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(irq_flag) & ~$past(ack_mask)) & ~irq_flag) == '0));

    for (genvar i = 0; i < N_SRC; i++) begin : g_chk
        localparam bit ACT = src_is_rising(i);

        // R4 R5 R8: a matching pin edge three samples back always lands, even under a clear.
        assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(xint_pin[i], 3) == ACT && $past(xint_pin[i], 4) != ACT)
            |-> irq_flag[i]);

        // R6: a flag only rises after a matching edge at the stated latency.
        assert_rise_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_flag[i]) |->
            ($past(xint_pin[i], 3) == ACT && $past(xint_pin[i], 4) != ACT));
    end
endmodule

bind xint_flag_bank xint_flag_bank_chk #(
    .N_SRC    (N_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xint_pin    (xint_pin),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .irq_flag    (irq_flag),
    .irq_any     (irq_any)
);

// File: tb/tb_xint_flag_bank.sv
`timescale 1ns/1ps
module tb_xint_flag_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] xint_pin = 4'b0000;
    logic [7:0] reg_addr = 8'h91;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic [3:0] irq_flag;
    logic       irq_any;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    xint_flag_bank dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xint_pin    (xint_pin),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .irq_flag    (irq_flag),
        .irq_any     (irq_any)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr    = a;
        reg_wr_data = d;
        reg_wr_en   = 1'b1;
        tick(1);
        reg_wr_en   = 1'b0;
        reg_addr    = 8'h91;
    endtask

    task automatic set_all();
        xint_pin = 4'b1010;
        tick(4);
        xint_pin = 4'b0101;
        tick(4);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 / R2 with pins low during reset
        tick(5);
        chk(irq_flag == 4'h0 && !irq_any, "R1 reset state", {irq_any, irq_flag}, 0);
        rst_n = 1'b1;
        tick(8);
        chk(irq_flag == 4'h0, "R2 release with pins low", irq_flag, 0);
        chk(reg_rd_data == 8'h00, "R3 readback after reset", reg_rd_data, 0);

        // R2 with pins high during reset
        rst_n = 1'b0;
        xint_pin = 4'b1111;
        tick(5);
        chk(irq_flag == 4'h0 && !irq_any, "R1 reset state pins high", {irq_any, irq_flag}, 0);
        rst_n = 1'b1;
        tick(8);
        chk(irq_flag == 4'h0, "R2 release with pins high", irq_flag, 0);

        // Polarity sweep: every source, both directions (R4 R5 R6 R9 R3)
        for (int i = 0; i < 4; i++) begin
            for (int nl = 0; nl < 2; nl++) begin
                bit       rising;
                bit       hit;
                logic [3:0] expv;
                rising = (i % 2) == 0;
                xint_pin[i] = ~nl[0];
                tick(4);
                wr(8'h91, 8'h00);
                xint_pin[i] = nl[0];
                tick(2);
                chk(irq_flag[i] == 1'b0, "R6 not visible after two edges", irq_flag, 0);
                tick(1);
                hit  = (rising == nl[0]);
                expv = hit ? (4'b0001 << i) : 4'b0000;
                chk(irq_flag == expv, rising ? "R4 rising source" : "R5 falling source",
                    irq_flag, expv);
                tick(1);
                chk(irq_any == hit, "R9 combined request", irq_any, hit);
                chk(reg_rd_data == {expv, 4'b0000}, "R3 bit placement", reg_rd_data,
                    {expv, 4'b0000});
            end
        end

        // Acknowledge mask sweep (R7)
        for (int m = 0; m < 16; m++) begin
            set_all();
            chk(irq_flag == 4'hF, "R4 R5 all sources set", irq_flag, 4'hF);
            wr(8'h91, {m[3:0], 4'b1010});
            chk(irq_flag == m[3:0], "R7 clear mask", irq_flag, m[3:0]);
        end

        // Sticky behaviour (R10)
        set_all();
        wr(8'h91, 8'hE0);
        chk(irq_flag == 4'b1110, "R7 single clear", irq_flag, 4'b1110);
        xint_pin[1] = 1'b1;
        tick(4);
        xint_pin[1] = 1'b0;
        tick(4);
        chk(irq_flag == 4'b1110, "R10 flag sticky through edges", irq_flag, 4'b1110);

        // Foreign address (R7 R3)
        wr(8'h90, 8'h00);
        chk(irq_flag == 4'b1110, "R7 other address ignored", irq_flag, 4'b1110);
        reg_addr = 8'h90;
        @(negedge clk);
        chk(reg_rd_data == 8'h00, "R3 other address reads zero", reg_rd_data, 0);
        reg_addr = 8'h91;

        // Set beats clear on the same edge (R8)
        wr(8'h91, 8'h00);
        chk(irq_flag == 4'h0, "R7 clear all", irq_flag, 0);
        xint_pin[0] = 1'b0;
        tick(4);
        xint_pin[0] = 1'b1;
        tick(2);
        reg_wr_data = 8'h00;
        reg_wr_en   = 1'b1;
        tick(1);
        reg_wr_en   = 1'b0;
        chk(irq_flag == 4'b0001, "R8 set wins over clear", irq_flag, 4'b0001);
        tick(1);
        chk(irq_any == 1'b1, "R9 any after collision", irq_any, 1);
        wr(8'h91, 8'h00);
        chk(irq_flag == 4'h0, "R7 clear after collision", irq_flag, 0);
        chk(irq_any == 1'b1, "R9 any lags one cycle", irq_any, 1);
        tick(1);
        chk(irq_any == 1'b0, "R9 any drops", irq_any, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule